// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block drives the enable pin of an external power-management device. It holds a second calendar alarm of six BCD bytes and compares it with the running time, which comes in as an input, on every timer-update strobe. When the alarm is armed and the compare hits, the block raises a sticky event flag and an interrupt. If power control is also granted, it drops the power-enable output so that the power device turns the system off.

Power comes back through four external wake inputs. Each input has its own enable bit and its own polarity bit. Each passes through a two-flop synchronizer before polarity and enable are applied. Once the output has gone low it stays low until an enabled wake input reaches its active level. Software must program the alarm at least two seconds ahead of the current time, because the compare runs only on timer updates.

Top module: `pmic_pwr_ctrl`

## Requirements
- R1: After reset `pwr_en_o` is 1, `irq_o` is 0, and every register reads 0.
- R2: Register map, by byte address. Alarm bytes sit at 0x80, 0x84, 0x88, 0x8C, 0x90 and 0x94, in the order seconds, minutes, hours, day, month, year; each keeps `wdata[7:0]` and reads back zero-extended. The control word at 0x98 keeps all 32 bits. In that word, bit x (x = 0..3) enables wake input x, bit 4+x sets its polarity (1 = active low), and bit 16 grants power control. Address 0x48 keeps only bit 4, the alarm arm bit. Address 0x44 shows the event flag in bit 7. Any other address reads 0, and writes to it have no effect.
- R3: An event happens when `tick_i` is 1, the arm bit is 1 and `now_i` equals all six alarm bytes. `now_i` is packed as {year, month, day, hour, minute, second}, with the second in [7:0]. An event sets the flag on the next edge. `irq_o` equals flag AND arm bit.
- R4: An equal time with `tick_i` low produces no event. A tick that matches while the arm bit is 0 also produces no event.
- R5: Writing 1 to bit 7 of 0x44 clears the flag, and writing 0 there has no effect. When an event and a clear fall in the same cycle, the flag ends up set.
- R6: An event while bit 16 is set drives `pwr_en_o` to 0 on the next edge. Without bit 16 the output stays 1 even though the flag sets.
- R7: While `pwr_en_o` is 0, a wake input that is enabled and held at its active level drives `pwr_en_o` to 1 on the third rising edge after the input changes. A wake input that is disabled, or held at its inactive level, has no effect.
- R8: Once off, `pwr_en_o` stays 0 until R7 applies. If an event and a wake hit fall in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| tick_i | input | 1 | Pulse: time counters hold a new value |
| now_i | input | 48 | Current BCD time {year,month,day,hour,min,sec} |
| wake_i | input | 4 | Asynchronous wake inputs |
| pwr_en_o | output | 1 | Power-enable to the power device, 1 = on |
| irq_o | output | 1 | Second-alarm interrupt |

## Verification
The bench applies directed ticks in which the time equals the alarm, and ticks where it does not. It repeats a matching time with the strobe low and a matching tick with the arm bit clear; these cases separate a correct compare from one that is level-triggered or ignores the arm bit. For wake inputs it holds an enabled input at its active level, a disabled input, and an active-low input at both levels, and counts edges to pin the synchronizer latency. A seeded random mix of register writes, matching and non-matching ticks and wake changes is then checked cycle by cycle against a bench model.

// File: rtl/pmic_pwr_pkg.sv
package pmic_pwr_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned FIELD_W = 8;
  localparam int unsigned N_FIELD = 6;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_ARM    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h98;
  localparam int unsigned STAT_BIT = 7;
  localparam int unsigned ARM_BIT  = 4;
  localparam int unsigned PCTL_BIT = 16;
endpackage

// File: rtl/pmic_alarm_cmp.sv
module pmic_alarm_cmp #(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned FIELD_W = 8,
  parameter int unsigned N_FIELD = 6,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [FIELD_W-1:0]         wdata_i,
  input  logic [N_FIELD*FIELD_W-1:0] now_i,
  output logic [N_FIELD*FIELD_W-1:0] alarm_o,
  output logic                       equal_o
);
  localparam int unsigned STRIDE = 4;

  for (genvar f = 0; f < N_FIELD; f++) begin : g_field
    localparam logic [ADDR_W-1:0] FADDR = BASE + ADDR_W'(STRIDE * f);
    logic [FIELD_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        q <= '0;
      else if (we_i && addr_i == FADDR)   q <= wdata_i;
    end
    assign alarm_o[f*FIELD_W +: FIELD_W] = q;

    a_r2_field_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == FADDR) |=> (alarm_o[f*FIELD_W +: FIELD_W] == $past(wdata_i)));
  end

  assign equal_o = (alarm_o == now_i);
endmodule

// File: rtl/pmic_wake_sync.sv
module pmic_wake_sync #(
  parameter int unsigned N_WAKE = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_WAKE-1:0] en_i,
  input  logic [N_WAKE-1:0] pol_i,
  output logic              hit_o
);
  logic [N_WAKE-1:0] sync;

  for (genvar w = 0; w < N_WAKE; w++) begin : g_sync
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh <= '0;
      else         sh <= {sh[STAGES-2:0], wake_i[w]};
    end
    assign sync[w] = sh[STAGES-1];
  end

  // pol=1: active low
  assign hit_o = |((sync ^ pol_i) & en_i);
endmodule

// File: rtl/pmic_pwr_ctrl.sv
module pmic_pwr_ctrl
  import pmic_pwr_pkg::*;
#(
  parameter int unsigned N_WAKE = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  input  logic                       tick_i,
  input  logic [N_FIELD*FIELD_W-1:0] now_i,
  input  logic [N_WAKE-1:0]          wake_i,
  output logic                       pwr_en_o,
  output logic                       irq_o
);
  localparam int unsigned POL_LSB = N_WAKE;
  localparam int unsigned ALARM_W = N_FIELD * FIELD_W;

  logic [DATA_W-1:0]  ctrl_q;
  logic               arm_q, stat_q, pwr_q;
  logic [ALARM_W-1:0] alarm;
  logic               equal, wake_hit, match, off_evt, stat_clr;

  pmic_alarm_cmp #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .N_FIELD(N_FIELD), .BASE(OFS_ALARM)
  ) u_alarm (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i[FIELD_W-1:0]), .now_i(now_i),
    .alarm_o(alarm), .equal_o(equal)
  );

  pmic_wake_sync #(.N_WAKE(N_WAKE), .STAGES(SYNC_STAGES)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .wake_i(wake_i),
    .en_i(ctrl_q[N_WAKE-1:0]), .pol_i(ctrl_q[POL_LSB +: N_WAKE]),
    .hit_o(wake_hit)
  );

  assign match    = tick_i && arm_q && equal;
  assign off_evt  = match && ctrl_q[PCTL_BIT];
  assign stat_clr = reg_we_i && reg_addr_i == OFS_STATUS && reg_wdata_i[STAT_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      arm_q  <= 1'b0;
      stat_q <= 1'b0;
      pwr_q  <= 1'b1;
    end else begin
      if (reg_we_i && reg_addr_i == OFS_CTRL) ctrl_q <= reg_wdata_i;
      if (reg_we_i && reg_addr_i == OFS_ARM)  arm_q  <= reg_wdata_i[ARM_BIT];
      // event wins over clear
      if (match)         stat_q <= 1'b1;
      else if (stat_clr) stat_q <= 1'b0;
      if (off_evt)                pwr_q <= 1'b0;
      else if (!pwr_q && wake_hit) pwr_q <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == OFS_STATUS)      reg_rdata_o[STAT_BIT] = stat_q;
    else if (reg_addr_i == OFS_ARM)    reg_rdata_o[ARM_BIT]  = arm_q;
    else if (reg_addr_i == OFS_CTRL)   reg_rdata_o = ctrl_q;
    else begin
      for (int f = 0; f < N_FIELD; f++) begin
        if (reg_addr_i == OFS_ALARM + ADDR_W'(4 * f))
          reg_rdata_o[FIELD_W-1:0] = alarm[f*FIELD_W +: FIELD_W];
      end
    end
  end

  assign pwr_en_o = pwr_q;
  assign irq_o    = stat_q && arm_q;

  a_r6_off_needs_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(tick_i && arm_q && ctrl_q[PCTL_BIT]));
  a_r7_on_needs_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_en_o) |-> $past(wake_hit));
  a_r3_flag_from_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_q) |-> $past(tick_i && arm_q));
  a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_clr && !tick_i) |=> !stat_q);
  a_r8_off_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_en_o && !wake_hit) |=> !pwr_en_o);
endmodule

// File: tb/sim_pmic_pwr_ctrl.sv
module sim_pmic_pwr_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we_v = 1'b0;
  logic [7:0]  addr_v = '0;
  logic [31:0] wdata_v = '0;
  logic [31:0] rdata;
  logic        tick_v = 1'b0;
  logic [47:0] now_v = '0;
  logic [3:0]  wake_v = '0;
  logic        pwr, irq;

  int total = 0;
  int bad = 0;

  logic [7:0]  m_alm [6];
  logic [31:0] m_ctrl;
  logic        m_arm, m_stat, m_pwr;
  logic [3:0]  m_s1, m_s2;

  always #(CLK_PERIOD/2) clk = ~clk;

  pmic_pwr_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we_v), .reg_addr_i(addr_v),
    .reg_wdata_i(wdata_v), .reg_rdata_o(rdata), .tick_i(tick_v),
    .now_i(now_v), .wake_i(wake_v), .pwr_en_o(pwr), .irq_o(irq)
  );

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [47:0] alarm_word();
    return {m_alm[5], m_alm[4], m_alm[3], m_alm[2], m_alm[1], m_alm[0]};
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    if (a == 8'h44) return {24'h0, m_stat, 7'h0};
    if (a == 8'h48) return {27'h0, m_arm, 4'h0};
    if (a == 8'h98) return m_ctrl;
    if (a >= 8'h80 && a <= 8'h94 && a[1:0] == 2'b00) return {24'h0, m_alm[(a - 8'h80) >> 2]};
    return '0;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 6; k++) m_alm[k] = '0;
    m_ctrl = '0; m_arm = 0; m_stat = 0; m_pwr = 1; m_s1 = '0; m_s2 = '0;
  endtask

  // one clock: update the model from the driven inputs, check at the falling edge
  task automatic cyc();
    logic hit, match, clr;
    @(posedge clk);
    hit   = |((m_s2 ^ m_ctrl[7:4]) & m_ctrl[3:0]);
    match = tick_v && m_arm && (now_v == alarm_word());
    clr   = we_v && addr_v == 8'h44 && wdata_v[7];
    if (match) m_stat = 1;
    else if (clr) m_stat = 0;
    if (match && m_ctrl[16]) m_pwr = 0;
    else if (!m_pwr && hit) m_pwr = 1;
    if (we_v) begin
      if (addr_v == 8'h98) m_ctrl = wdata_v;
      if (addr_v == 8'h48) m_arm = wdata_v[4];
      if (addr_v >= 8'h80 && addr_v <= 8'h94 && addr_v[1:0] == 2'b00)
        m_alm[(addr_v - 8'h80) >> 2] = wdata_v[7:0];
    end
    m_s2 = m_s1;
    m_s1 = wake_v;
    @(negedge clk);
    chk(pwr === m_pwr, "R6 pwr_en_o", {31'h0, pwr}, {31'h0, m_pwr});
    chk(irq === (m_stat && m_arm), "R3 irq_o", {31'h0, irq}, {31'h0, m_stat && m_arm});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    we_v = 1; addr_v = a; wdata_v = d;
    cyc();
    we_v = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] exp, string tag);
    addr_v = a;
    #1;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic tick_at(logic [47:0] t);
    now_v = t; tick_v = 1;
    cyc();
    tick_v = 0;
  endtask

  logic [7:0] vals [6] = '{8'h12, 8'h34, 8'h05, 8'h21, 8'h07, 8'h24};
  logic [7:0] raddr [9] = '{8'h80, 8'h84, 8'h88, 8'h8C, 8'h90, 8'h94, 8'h98, 8'h44, 8'h48};

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk(pwr === 1'b1, "R1 pwr after reset", {31'h0, pwr}, 32'h1);
    chk(irq === 1'b0, "R1 irq after reset", {31'h0, irq}, 32'h0);
    for (int k = 0; k < 9; k++) rd_chk(raddr[k], 32'h0, "R1 reg after reset");

    // R2 register map
    for (int k = 0; k < 6; k++) wr(8'(8'h80 + 4 * k), {24'hABCDEF, vals[k]});
    for (int k = 0; k < 6; k++) rd_chk(8'(8'h80 + 4 * k), {24'h0, vals[k]}, "R2 alarm byte");
    wr(8'h98, 32'hFFFF_FFFF);
    rd_chk(8'h98, 32'hFFFF_FFFF, "R2 ctrl word");
    wr(8'h98, 32'h0);
    wr(8'h48, 32'hFF);
    rd_chk(8'h48, 32'h10, "R2 arm bit only");
    wr(8'h4C, 32'hFFFF_FFFF);
    rd_chk(8'h4C, 32'h0, "R2 unmapped reads zero");
    for (int k = 0; k < 9; k++) rd_chk(raddr[k], exp_rd(raddr[k]), "R2 unmapped write ignored");

    // R3 event with power control off (R6 second half)
    tick_at(alarm_word());
    rd_chk(8'h44, 32'h80, "R3 flag set");
    chk(irq === 1'b1, "R3 irq raised", {31'h0, irq}, 32'h1);
    chk(pwr === 1'b1, "R6 no grant keeps power", {31'h0, pwr}, 32'h1);

    // R5 write-one-to-clear
    wr(8'h44, 32'h7F);
    rd_chk(8'h44, 32'h80, "R5 write zero keeps flag");
    wr(8'h44, 32'h80);
    rd_chk(8'h44, 32'h0, "R5 write one clears");

    // R4 no tick, no arm
    now_v = alarm_word();
    repeat (4) cyc();
    rd_chk(8'h44, 32'h0, "R4 equal without tick");
    wr(8'h48, 32'h0);
    tick_at(alarm_word());
    rd_chk(8'h44, 32'h0, "R4 tick while disarmed");
    chk(irq === 1'b0, "R4 irq quiet", {31'h0, irq}, 32'h0);

    // R6 / R7 / R8 active-high wake on input 0
    wr(8'h48, 32'h10);
    wr(8'h98, 32'h0001_0001);
    wake_v = 4'b0000;
    repeat (3) cyc();
    tick_at(alarm_word());
    chk(pwr === 1'b0, "R6 power dropped", {31'h0, pwr}, 32'h0);
    wake_v = 4'b0010;
    repeat (6) cyc();
    chk(pwr === 1'b0, "R8 disabled wake ignored, stays off", {31'h0, pwr}, 32'h0);
    wake_v = 4'b0011;
    cyc(); cyc();
    chk(pwr === 1'b0, "R7 not yet after two edges", {31'h0, pwr}, 32'h0);
    cyc();
    chk(pwr === 1'b1, "R7 on after third edge", {31'h0, pwr}, 32'h1);
    wr(8'h44, 32'h80);

    // R7 active-low on input 2
    wake_v = 4'b0100;
    wr(8'h98, 32'h0001_0044);
    repeat (3) cyc();
    tick_at(alarm_word());
    chk(pwr === 1'b0, "R6 power dropped again", {31'h0, pwr}, 32'h0);
    repeat (5) cyc();
    chk(pwr === 1'b0, "R7 inactive level ignored", {31'h0, pwr}, 32'h0);
    wake_v = 4'b0000;
    repeat (3) cyc();
    chk(pwr === 1'b1, "R7 active-low wake", {31'h0, pwr}, 32'h1);

    // R8 event beats a wake hit present in the same cycle; R5 event beats clear
    we_v = 1; addr_v = 8'h44; wdata_v = 32'h80;
    tick_at(alarm_word());
    we_v = 0;
    chk(pwr === 1'b0, "R8 event wins over wake", {31'h0, pwr}, 32'h0);
    rd_chk(8'h44, 32'h80, "R5 event wins over clear");
    cyc();
    chk(pwr === 1'b1, "R8 wake restores next edge", {31'h0, pwr}, 32'h1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 3) == 0) wake_v = 4'($urandom);
      case (op)
        0, 1: wr(8'(8'h80 + 4 * $urandom_range(0, 5)), $urandom);
        2:    wr(8'h98, $urandom);
        3:    wr(8'h48, ($urandom_range(0, 3) != 0) ? 32'h10 : 32'h0);
        4:    wr(8'h44, $urandom);
        5, 6: tick_at(alarm_word());
        7:    tick_at({$urandom, 16'($urandom)});
        default: begin now_v = alarm_word(); cyc(); end
      endcase
      if (i % 5 == 0) begin
        logic [7:0] a;
        a = ($urandom_range(0, 9) == 0) ? 8'h4C : raddr[$urandom_range(0, 8)];
        rd_chk(a, exp_rd(a), "R2 random readback");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule